// File: doc/BRIEF.md
# AXI4 Burst Memory Slave

This block is an AXI4 memory-mapped slave that keeps its contents in a small word array inside the block. A master writes bursts through the write address, write data and write response channels, and reads bursts through the read address and read data channels. The two directions have separate control paths. A read burst can run while a write burst is in progress, and each direction holds at most one transaction at a time.

A write has three steps. The slave accepts the address, then LEN+1 data beats, then returns one response. A read has two steps: the slave accepts the address, then returns LEN+1 data beats. The beat address for each step comes from a burst address stepper, which supports the fixed, incrementing and wrapping modes. The slave applies write byte strobes and returns the transaction ID with each response. If a beat falls outside the array, or if the master's WLAST does not line up with the burst length, the slave still runs the full burst and reports an error response.

Top module: `axi_burst_mem`

## Requirements
- R1: A beat or address transfer on any channel happens only on a rising clock edge where that channel's valid and ready are both high. A valid that is not matched by ready changes no state.
- R2: aw_ready is low from the cycle after a write address is accepted until the cycle after that burst's response is accepted. ar_ready is low from the cycle after a read address is accepted until the cycle after that burst's last beat is accepted.
- R3: After a write address is accepted, w_ready stays high for exactly LEN+1 accepted beats. The slave then raises b_valid once, with b_id equal to the accepted write ID.
- R4: During a write beat, only the byte lanes whose w_strb bit is set (bit k selects bits 8k+7..8k) are updated. All other lanes keep their old contents.
- R5: Once b_valid is high, it stays high until b_ready is high, and b_resp and b_id do not change during that time.
- R6: Once r_valid is high, it stays high until r_ready is high, and r_data, r_resp, r_last and r_id do not change during that time.
- R7: A read burst returns exactly LEN+1 beats. r_last is high on the final beat only, and r_id equals the accepted read ID.
- R8: Each beat address follows the burst code: 2'b00 keeps the same address; 2'b01 moves to the next aligned address, 2^SIZE bytes on; 2'b10 does the same but wraps inside the aligned window of (LEN+1)*2^SIZE bytes.
- R9: If w_last is high on a beat that is not beat LEN, or low on beat LEN, the burst still takes LEN+1 beats, in-range beats are still stored, and b_resp is SLVERR (2'b10). A clean in-range burst returns OKAY (2'b00).
- R10: A beat whose word index (address divided by the bus width in bytes) is DEPTH or more stores nothing and makes b_resp SLVERR. On a read, such a beat returns zero data with r_resp SLVERR, and the burst still takes its full beat count.
- R11: Data written as a 4-beat incrementing burst of 4-byte beats starting at address 0 reads back unchanged with the same burst shape.
- R12: While reset is asserted and right after reset, aw_ready and ar_ready are high and b_valid, r_valid and w_ready are low.
- R13: A read burst runs while a write burst is in progress. When a read beat and a write beat hit the same word in the same cycle, the read returns the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address ready |
| aw_id | input | ID_W | Write transaction ID |
| aw_addr | input | ADDR_W | Write start byte address |
| aw_len | input | 8 | Write beats minus one |
| aw_size | input | 3 | log2 of bytes per write beat |
| aw_burst | input | 2 | Write burst code |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Write data ready |
| w_data | input | DATA_W | Write data |
| w_strb | input | DATA_W/8 | Write byte enables |
| w_last | input | 1 | Master's final-beat marker |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| b_id | output | ID_W | Write response ID |
| b_resp | output | 2 | Write response status |
| ar_valid | input | 1 | Read address valid |
| ar_ready | output | 1 | Read address ready |
| ar_id | input | ID_W | Read transaction ID |
| ar_addr | input | ADDR_W | Read start byte address |
| ar_len | input | 8 | Read beats minus one |
| ar_size | input | 3 | log2 of bytes per read beat |
| ar_burst | input | 2 | Read burst code |
| r_valid | output | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_id | output | ID_W | Read response ID |
| r_data | output | DATA_W | Read data |
| r_resp | output | 2 | Read beat status |
| r_last | output | 1 | Final read beat |

## Verification
The bench builds the block with ADDR_W=8, DATA_W=32, ID_W=4 and DEPTH=16. The array then covers only bytes 0 to 63 of a 256-byte address space, so a short burst can start inside the array and run past its end. The 16 words also fit in one full-length fill burst. With these values a wrapping window of 16 bytes lies inside the array, so its wrap point can be read back through an incrementing read. A write and a read can also be aimed at neighbouring regions at the same time.

// File: rtl/axbm_pkg.sv
package axbm_pkg;
  localparam logic [1:0] BURST_FIXED = 2'b00;
  localparam logic [1:0] BURST_INCR  = 2'b01;
  localparam logic [1:0] BURST_WRAP  = 2'b10;
  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  typedef enum logic [1:0] {WS_ADDR, WS_DATA, WS_RESP} wr_state_e;
  typedef enum logic       {RS_ADDR, RS_DATA}          rd_state_e;
endpackage

// File: rtl/axbm_addr_step.sv
module axbm_addr_step
  import axbm_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [2:0]        size,
  input  logic [7:0]        len,
  input  logic [1:0]        burst,
  output logic [ADDR_W-1:0] next_addr
);
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] win_mask;

  always_comb begin
    step     = ADDR_W'(1) << size;
    win_mask = ((ADDR_W'(len) + ADDR_W'(1)) << size) - ADDR_W'(1);
    case (burst)
      BURST_FIXED: next_addr = cur_addr;
      BURST_WRAP:  next_addr = (cur_addr & ~win_mask) | ((cur_addr + step) & win_mask);
      default:     next_addr = (cur_addr & ~(step - ADDR_W'(1))) + step;
    endcase
  end
endmodule

// File: rtl/axbm_wr_path.sv
module axbm_wr_path
  import axbm_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  parameter int DEPTH  = 64,
  localparam int STRB_W  = DATA_W / 8,
  localparam int BYTE_SH = $clog2(STRB_W),
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aw_valid,
  output logic              aw_ready,
  input  logic [ID_W-1:0]   aw_id,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic [7:0]        aw_len,
  input  logic [2:0]        aw_size,
  input  logic [1:0]        aw_burst,
  input  logic              w_valid,
  output logic              w_ready,
  input  logic [DATA_W-1:0] w_data,
  input  logic [STRB_W-1:0] w_strb,
  input  logic              w_last,
  output logic              b_valid,
  input  logic              b_ready,
  output logic [ID_W-1:0]   b_id,
  output logic [1:0]        b_resp,
  output logic              mem_we,
  output logic [IDX_W-1:0]  mem_idx,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [STRB_W-1:0] mem_wstrb
);
  wr_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q, step_addr;
  logic [7:0]        len_q, cnt_q;
  logic [2:0]        size_q;
  logic [1:0]        burst_q;
  logic [ID_W-1:0]   id_q;
  logic              err_q, err_d;
  logic              aw_fire, w_fire, b_fire, beat_last, beat_ok;

  axbm_addr_step #(.ADDR_W(ADDR_W)) u_step (
    .cur_addr (addr_q),
    .size     (size_q),
    .len      (len_q),
    .burst    (burst_q),
    .next_addr(step_addr)
  );

  always_comb begin
    aw_ready  = (state_q == WS_ADDR);
    w_ready   = (state_q == WS_DATA);
    b_valid   = (state_q == WS_RESP);
    b_id      = id_q;
    b_resp    = err_q ? RESP_SLVERR : RESP_OKAY;
    aw_fire   = aw_valid && aw_ready;
    w_fire    = w_valid && w_ready;
    b_fire    = b_valid && b_ready;
    beat_last = (cnt_q == len_q);
    beat_ok   = 32'(addr_q >> BYTE_SH) < 32'(DEPTH);
    mem_we    = w_fire && beat_ok;
    mem_idx   = IDX_W'(addr_q >> BYTE_SH);
    mem_wdata = w_data;
    mem_wstrb = w_strb;
    err_d     = err_q | ~beat_ok | (w_last != beat_last);
    state_d   = state_q;
    case (state_q)
      WS_ADDR: if (aw_fire) state_d = WS_DATA;
      WS_DATA: if (w_fire && beat_last) state_d = WS_RESP;
      default: if (b_fire) state_d = WS_ADDR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WS_ADDR;
      cnt_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (aw_fire) begin
        cnt_q <= '0;
        err_q <= 1'b0;
      end else if (w_fire) begin
        cnt_q <= cnt_q + 8'd1;
        err_q <= err_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (aw_fire) begin
      addr_q  <= aw_addr;
      len_q   <= aw_len;
      size_q  <= aw_size;
      burst_q <= aw_burst;
      id_q    <= aw_id;
    end else if (w_fire) begin
      addr_q  <= step_addr;
    end
  end

  a_r2_aw_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_valid && aw_ready) |=> !aw_ready);
  a_r3_resp_after_final: assert property (@(posedge clk) disable iff (!rst_n)
    (w_fire && beat_last) |=> (b_valid && !w_ready));
  a_r3_no_early_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (w_fire && !beat_last) |=> (!b_valid && w_ready));
  a_r5_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && !b_ready) |=> (b_valid && $stable(b_resp) && $stable(b_id)));
endmodule

// File: rtl/axbm_rd_path.sv
module axbm_rd_path
  import axbm_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  parameter int DEPTH  = 64,
  localparam int STRB_W  = DATA_W / 8,
  localparam int BYTE_SH = $clog2(STRB_W),
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ar_valid,
  output logic              ar_ready,
  input  logic [ID_W-1:0]   ar_id,
  input  logic [ADDR_W-1:0] ar_addr,
  input  logic [7:0]        ar_len,
  input  logic [2:0]        ar_size,
  input  logic [1:0]        ar_burst,
  output logic              r_valid,
  input  logic              r_ready,
  output logic [ID_W-1:0]   r_id,
  output logic [DATA_W-1:0] r_data,
  output logic [1:0]        r_resp,
  output logic              r_last,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [DATA_W-1:0] rd_word
);
  rd_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q, step_addr, look_addr;
  logic [7:0]        len_q, cnt_q;
  logic [2:0]        size_q;
  logic [1:0]        burst_q;
  logic [ID_W-1:0]   id_q;
  logic [DATA_W-1:0] data_q;
  logic [1:0]        resp_q;
  logic              ar_fire, r_fire, beat_last, look_ok, load_en;

  axbm_addr_step #(.ADDR_W(ADDR_W)) u_step (
    .cur_addr (addr_q),
    .size     (size_q),
    .len      (len_q),
    .burst    (burst_q),
    .next_addr(step_addr)
  );

  always_comb begin
    ar_ready  = (state_q == RS_ADDR);
    r_valid   = (state_q == RS_DATA);
    r_id      = id_q;
    r_data    = data_q;
    r_resp    = resp_q;
    beat_last = (cnt_q == len_q);
    r_last    = r_valid && beat_last;
    ar_fire   = ar_valid && ar_ready;
    r_fire    = r_valid && r_ready;
    look_addr = (state_q == RS_ADDR) ? ar_addr : step_addr;
    look_ok   = 32'(look_addr >> BYTE_SH) < 32'(DEPTH);
    rd_idx    = IDX_W'(look_addr >> BYTE_SH);
    load_en   = ar_fire || (r_fire && !beat_last);
    state_d   = state_q;
    case (state_q)
      RS_ADDR: if (ar_fire) state_d = RS_DATA;
      default: if (r_fire && beat_last) state_d = RS_ADDR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_ADDR;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (ar_fire) cnt_q <= '0;
      else if (r_fire && !beat_last) cnt_q <= cnt_q + 8'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (ar_fire) begin
      len_q   <= ar_len;
      size_q  <= ar_size;
      burst_q <= ar_burst;
      id_q    <= ar_id;
    end
    if (load_en) begin
      addr_q <= look_addr;
      data_q <= look_ok ? rd_word : '0;
      resp_q <= look_ok ? RESP_OKAY : RESP_SLVERR;
    end
  end

  a_r2_ar_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid && ar_ready) |=> !ar_ready);
  a_r6_r_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_data) && $stable(r_resp)
                               && $stable(r_last) && $stable(r_id)));
  a_r7_reopen_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && r_ready && r_last) |=> (ar_ready && !r_valid));
  a_r10_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && r_resp == RESP_SLVERR) |-> (r_data == '0));
endmodule

// File: rtl/axi_burst_mem.sv
module axi_burst_mem
  import axbm_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  parameter int DEPTH  = 64,
  localparam int STRB_W = DATA_W / 8,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aw_valid,
  output logic              aw_ready,
  input  logic [ID_W-1:0]   aw_id,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic [7:0]        aw_len,
  input  logic [2:0]        aw_size,
  input  logic [1:0]        aw_burst,
  input  logic              w_valid,
  output logic              w_ready,
  input  logic [DATA_W-1:0] w_data,
  input  logic [STRB_W-1:0] w_strb,
  input  logic              w_last,
  output logic              b_valid,
  input  logic              b_ready,
  output logic [ID_W-1:0]   b_id,
  output logic [1:0]        b_resp,
  input  logic              ar_valid,
  output logic              ar_ready,
  input  logic [ID_W-1:0]   ar_id,
  input  logic [ADDR_W-1:0] ar_addr,
  input  logic [7:0]        ar_len,
  input  logic [2:0]        ar_size,
  input  logic [1:0]        ar_burst,
  output logic              r_valid,
  input  logic              r_ready,
  output logic [ID_W-1:0]   r_id,
  output logic [DATA_W-1:0] r_data,
  output logic [1:0]        r_resp,
  output logic              r_last
);
  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic [DATA_W-1:0] store_q [DEPTH];
  logic              mem_we;
  logic [IDX_W-1:0]  mem_idx, rd_idx;
  logic [DATA_W-1:0] mem_wdata, rd_word;
  logic [STRB_W-1:0] mem_wstrb;

  // assert asynchronously, release two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  always_ff @(posedge clk) begin
    if (mem_we) begin
      for (int b = 0; b < STRB_W; b++) begin
        if (mem_wstrb[b]) store_q[mem_idx][8*b +: 8] <= mem_wdata[8*b +: 8];
      end
    end
  end
  assign rd_word = store_q[rd_idx];

  axbm_wr_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .DEPTH(DEPTH)) u_wr (
    .clk(clk), .rst_n(rst_sync_n),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_addr(aw_addr),
    .aw_len(aw_len), .aw_size(aw_size), .aw_burst(aw_burst),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_strb(w_strb), .w_last(w_last),
    .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id), .b_resp(b_resp),
    .mem_we(mem_we), .mem_idx(mem_idx), .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb)
  );

  axbm_rd_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .DEPTH(DEPTH)) u_rd (
    .clk(clk), .rst_n(rst_sync_n),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_addr(ar_addr),
    .ar_len(ar_len), .ar_size(ar_size), .ar_burst(ar_burst),
    .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id), .r_data(r_data),
    .r_resp(r_resp), .r_last(r_last),
    .rd_idx(rd_idx), .rd_word(rd_word)
  );

  a_r12_idle_in_reset: assert property (@(posedge clk)
    !rst_sync_n |-> (aw_ready && ar_ready && !b_valid && !r_valid && !w_ready));
endmodule

// File: tb/axi_burst_mem_bench.sv
module axi_burst_mem_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        aw_valid, aw_ready, w_valid, w_ready, w_last, b_valid, b_ready;
  logic        ar_valid, ar_ready, r_valid, r_ready, r_last;
  logic [3:0]  aw_id, b_id, ar_id, r_id, w_strb;
  logic [7:0]  aw_addr, ar_addr, aw_len, ar_len;
  logic [2:0]  aw_size, ar_size;
  logic [1:0]  aw_burst, ar_burst, b_resp, r_resp;
  logic [31:0] w_data, r_data;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  axi_burst_mem #(.ADDR_W(8), .DATA_W(32), .ID_W(4), .DEPTH(16)) u_axi_burst_mem (
    .clk(clk), .rst_n(rst_n),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_addr(aw_addr),
    .aw_len(aw_len), .aw_size(aw_size), .aw_burst(aw_burst),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_strb(w_strb), .w_last(w_last),
    .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id), .b_resp(b_resp),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_addr(ar_addr),
    .ar_len(ar_len), .ar_size(ar_size), .ar_burst(ar_burst),
    .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id), .r_data(r_data),
    .r_resp(r_resp), .r_last(r_last)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] mm [16];
  int mw_st, mw_addr, mw_len, mw_size, mw_burst, mw_id, mw_cnt;
  int mr_st, mr_addr, mr_len, mr_size, mr_burst, mr_id, mr_cnt;
  bit mw_err;
  logic [31:0] mr_data;
  logic [1:0]  mr_resp;

  function automatic int m_next(int a, int sz, int ln, int bt);
    int nb, span, base;
    nb = 1 << sz;
    if (bt == 0) return a;
    if (bt == 2) begin
      span = (ln + 1) * nb;
      base = (a / span) * span;
      return base + ((a - base + nb) % span);
    end
    return ((a / nb) * nb + nb) % 256;
  endfunction

  task automatic m_load(input int a);
    if (a / 4 < 16) begin mr_data = mm[a / 4]; mr_resp = 2'b00; end
    else            begin mr_data = 32'h0;     mr_resp = 2'b10; end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mw_st = 0; mr_st = 0; mw_cnt = 0; mr_cnt = 0; mw_err = 0;
    end else begin
      // read side first: a same-edge write is not visible to it
      if (mr_st == 0) begin
        if (ar_valid) begin
          mr_addr = ar_addr; mr_len = ar_len; mr_size = ar_size; mr_burst = ar_burst;
          mr_id = ar_id; mr_cnt = 0; m_load(mr_addr); mr_st = 1;
        end
      end else if (r_ready) begin
        if (mr_cnt == mr_len) mr_st = 0;
        else begin
          mr_addr = m_next(mr_addr, mr_size, mr_len, mr_burst);
          mr_cnt++; m_load(mr_addr);
        end
      end
      if (mw_st == 0) begin
        if (aw_valid) begin
          mw_addr = aw_addr; mw_len = aw_len; mw_size = aw_size; mw_burst = aw_burst;
          mw_id = aw_id; mw_cnt = 0; mw_err = 0; mw_st = 1;
        end
      end else if (mw_st == 1) begin
        if (w_valid) begin
          if (mw_addr / 4 < 16) begin
            for (int k = 0; k < 4; k++)
              if (w_strb[k]) mm[mw_addr / 4][8*k +: 8] = w_data[8*k +: 8];
          end else mw_err = 1;
          if (w_last != (mw_cnt == mw_len)) mw_err = 1;
          if (mw_cnt == mw_len) mw_st = 2;
          else begin mw_addr = m_next(mw_addr, mw_size, mw_len, mw_burst); mw_cnt++; end
        end
      end else if (b_ready) mw_st = 0;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk("R2 aw_ready", 32'(aw_ready), 32'(mw_st == 0));
      chk("R2 ar_ready", 32'(ar_ready), 32'(mr_st == 0));
      chk("R3 w_ready",  32'(w_ready),  32'(mw_st == 1));
      chk("R5 b_valid",  32'(b_valid),  32'(mw_st == 2));
      chk("R6 r_valid",  32'(r_valid),  32'(mr_st == 1));
      if (mw_st == 2) begin
        chk("R3 b_id", 32'(b_id), 32'(mw_id));
        chk("R9/R10 b_resp", 32'(b_resp), mw_err ? 32'd2 : 32'd0);
      end
      if (mr_st == 1) begin
        chk("R7 r_id",     32'(r_id),   32'(mr_id));
        chk("R7 r_last",   32'(r_last), 32'(mr_cnt == mr_len));
        chk("R8 r_data",   r_data,      mr_data);
        chk("R10 r_resp",  32'(r_resp), 32'(mr_resp));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cycles);
      report();
    end
  end

  // ---------------- drivers ----------------
  logic [31:0] wd [16];
  logic [3:0]  ws [16];
  bit          wl [16];
  logic [31:0] rd [16];
  logic [1:0]  rr [16];
  bit          rl [16];
  logic [1:0]  got_bresp;
  logic [3:0]  got_bid, got_rid;

  task automatic aw_send(input int a, input int id, input int ln, input int sz, input int bt);
    bit rdy;
    aw_valid = 1; aw_addr = 8'(a); aw_id = 4'(id); aw_len = 8'(ln);
    aw_size = 3'(sz); aw_burst = 2'(bt);
    while (1) begin rdy = aw_ready; @(posedge clk); if (rdy) break; end
    @(negedge clk); aw_valid = 0;
  endtask

  task automatic w_beat(input int i, input int gap);
    bit rdy;
    repeat (gap) @(negedge clk);
    w_valid = 1; w_data = wd[i]; w_strb = ws[i]; w_last = wl[i];
    while (1) begin rdy = w_ready; @(posedge clk); if (rdy) break; end
    @(negedge clk); w_valid = 0;
  endtask

  task automatic b_take(input int dly);
    bit v;
    repeat (dly) @(negedge clk);
    b_ready = 1;
    while (1) begin
      v = b_valid; got_bresp = b_resp; got_bid = b_id;
      @(posedge clk); if (v) break;
    end
    @(negedge clk); b_ready = 0;
  endtask

  task automatic do_write(input int a, input int id, input int ln, input int bt, input int dly);
    aw_send(a, id, ln, 2, bt);
    for (int i = 0; i <= ln; i++) w_beat(i, dly);
    b_take(dly);
  endtask

  task automatic do_read(input int a, input int id, input int ln, input int bt, input int dly);
    bit v;
    ar_valid = 1; ar_addr = 8'(a); ar_id = 4'(id); ar_len = 8'(ln);
    ar_size = 3'd2; ar_burst = 2'(bt);
    while (1) begin v = ar_ready; @(posedge clk); if (v) break; end
    @(negedge clk); ar_valid = 0;
    for (int i = 0; i <= ln; i++) begin
      repeat (dly) @(negedge clk);
      r_ready = 1;
      while (1) begin
        v = r_valid; rd[i] = r_data; rr[i] = r_resp; rl[i] = r_last; got_rid = r_id;
        @(posedge clk); if (v) break;
      end
      @(negedge clk); r_ready = 0;
    end
  endtask

  task automatic set_w(input int i, input logic [31:0] d, input logic [3:0] s, input bit l);
    wd[i] = d; ws[i] = s; wl[i] = l;
  endtask

  initial begin
    rst_n = 0;
    aw_valid = 0; w_valid = 0; b_ready = 0; ar_valid = 0; r_ready = 0;
    aw_id = 0; aw_addr = 0; aw_len = 0; aw_size = 0; aw_burst = 0;
    w_data = 0; w_strb = 0; w_last = 0;
    ar_id = 0; ar_addr = 0; ar_len = 0; ar_size = 0; ar_burst = 0;
    repeat (3) @(negedge clk);
    chk("R12 aw_ready in reset", 32'(aw_ready), 1);
    chk("R12 ar_ready in reset", 32'(ar_ready), 1);
    chk("R12 b_valid in reset",  32'(b_valid), 0);
    chk("R12 r_valid in reset",  32'(r_valid), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R12 w_ready after reset", 32'(w_ready), 0);

    // fill the whole array with one 16-beat incrementing burst
    for (int i = 0; i < 16; i++) set_w(i, 32'hA000_0000 + 32'(i), 4'hF, i == 15);
    do_write(0, 3, 15, 1, 0);
    chk("R3 fill b_resp", 32'(got_bresp), 0);
    chk("R3 fill b_id",   32'(got_bid), 3);

    // R11: 4-beat incrementing write then identical read
    for (int i = 0; i < 4; i++) set_w(i, 32'h10 + 32'(i), 4'hF, i == 3);
    do_write(0, 1, 3, 1, 0);
    do_read(0, 5, 3, 1, 0);
    for (int i = 0; i < 4; i++) begin
      chk("R11 readback", rd[i], 32'h10 + 32'(i));
      chk("R7 r_last position", 32'(rl[i]), 32'(i == 3));
    end
    chk("R7 r_id echo", 32'(got_rid), 5);

    // R4: partial strobes on word 5
    set_w(0, 32'hDEAD_BEEF, 4'b0101, 1);
    do_write(8'h14, 2, 0, 1, 0);
    do_read(8'h14, 2, 0, 1, 0);
    chk("R4 strobe merge", rd[0], 32'hA0AD_00EF);

    // R8 fixed: three beats to one word
    for (int i = 0; i < 3; i++) set_w(i, 32'(i + 1), 4'hF, i == 2);
    do_write(8'h18, 4, 2, 0, 0);
    do_read(8'h18, 4, 1, 0, 0);
    chk("R8 fixed beat0", rd[0], 32'd3);
    chk("R8 fixed beat1", rd[1], 32'd3);
    do_read(8'h1C, 4, 0, 1, 0);
    chk("R8 fixed neighbour untouched", rd[0], 32'hA000_0007);

    // R8 wrap: start at 0x28 in a 16-byte window
    for (int i = 0; i < 4; i++) set_w(i, 32'hB0 + 32'(i), 4'hF, i == 3);
    do_write(8'h28, 6, 3, 2, 0);
    do_read(8'h20, 6, 3, 1, 0);
    chk("R8 wrap w0", rd[0], 32'hB2);
    chk("R8 wrap w1", rd[1], 32'hB3);
    chk("R8 wrap w2", rd[2], 32'hB0);
    chk("R8 wrap w3", rd[3], 32'hB1);
    do_read(8'h2C, 6, 3, 2, 0);
    chk("R8 wrap read b0", rd[0], 32'hB1);
    chk("R8 wrap read b1", rd[1], 32'hB2);

    // R9: early and missing last markers
    set_w(0, 32'hC0, 4'hF, 0); set_w(1, 32'hC1, 4'hF, 1); set_w(2, 32'hC2, 4'hF, 1);
    do_write(8'h30, 7, 2, 1, 0);
    chk("R9 early last b_resp", 32'(got_bresp), 2);
    do_read(8'h30, 7, 2, 1, 0);
    chk("R9 early last stored b2", rd[2], 32'hC2);
    chk("R9 early last r_resp", 32'(rr[2]), 0);
    set_w(0, 32'hD0, 4'hF, 0); set_w(1, 32'hD1, 4'hF, 0);
    do_write(8'h38, 8, 1, 1, 0);
    chk("R9 missing last b_resp", 32'(got_bresp), 2);
    do_read(8'h38, 8, 1, 1, 0);
    chk("R9 missing last stored", rd[1], 32'hD1);

    // R10: burst runs off the end of the array
    for (int i = 0; i < 4; i++) set_w(i, 32'hE0 + 32'(i), 4'hF, i == 3);
    do_write(8'h38, 9, 3, 1, 0);
    chk("R10 write b_resp", 32'(got_bresp), 2);
    do_read(8'h38, 9, 3, 1, 0);
    chk("R10 in-range b0", rd[0], 32'hE0);
    chk("R10 in-range b1", rd[1], 32'hE1);
    chk("R10 out data b2", rd[2], 0);
    chk("R10 out resp b3", 32'(rr[3]), 2);
    chk("R10 full length last", 32'(rl[3]), 1);
    do_read(8'h80, 9, 0, 1, 0);
    chk("R10 fully outside", 32'(rr[0]), 2);

    // R1/R5/R6: stalls on every channel
    set_w(0, 32'hF0, 4'hF, 0); set_w(1, 32'hF1, 4'hF, 1);
    do_write(0, 10, 1, 1, 3);
    chk("R5 stalled b_resp", 32'(got_bresp), 0);
    chk("R1 stalled b_id", 32'(got_bid), 10);
    do_read(0, 11, 1, 1, 2);
    chk("R6 stalled beat0", rd[0], 32'hF0);
    chk("R6 stalled beat1", rd[1], 32'hF1);

    // R13: concurrent write and read bursts
    for (int i = 0; i < 4; i++) set_w(i, 32'h90 + 32'(i), 4'hF, i == 3);
    fork
      do_write(8'h10, 12, 3, 1, 1);
      do_read(8'h20, 13, 3, 1, 0);
    join
    chk("R13 read during write", rd[0], 32'hB2);
    chk("R13 write during read", 32'(got_bresp), 0);
    do_read(8'h10, 13, 3, 1, 0);
    chk("R13 written words", rd[3], 32'h93);

    repeat (3) @(negedge clk);
    done = 1;
    report();
  end
endmodule